// File: doc/BRIEF.md
# Transfer-Completion Interrupt Controller

This block sits between a hardware transfer engine and the CPU's interrupt logic. Each of fourteen interrupt sources can be handed to a transfer channel instead of taking a normal software interrupt. For every source the block keeps three pieces of state: a channel-enable bit, an 8-bit transfer counter and a completion flag. Each finished transfer on an enabled channel counts the counter down by one. When the counter hits zero, the channel is switched off and the completion flag is raised in the same clock edge. The source then goes back to ordinary interrupt service.

While any completion flag is set, the block requests an interrupt. When the CPU acknowledges, the block picks the flag in the highest bit position. In that same cycle it presents the 24-bit vector address of that source. Software reads and writes the enable and completion registers, loads the counters and reads the capture-pending inputs through a small register port. Two of the sources each stand for a pair of capture channels. Their completion flags follow the pending state of those pairs instead of the acknowledge.

The block also decodes a channel control byte into its 3-bit mode field and its 5-bit argument field.

Top module: `xfer_done_intc`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), all enable bits, completion flags and counters are zero, the completion register at address 0x06 reads 0x0000 and eos_req is low.
- R2: On a rising edge where xfer_stb[b] is high, enable bit b is set and counter b is nonzero, counter b goes down by one. When enable bit b is clear, the strobe leaves counter b unchanged. Counter b is loaded from reg_wdata[7:0] by a write to address 0x20+b.
- R3: On the edge where an enabled counter goes from 1 to 0, enable bit b clears and completion flag b sets, both on that same edge.
- R4: Hardware never sets an enable bit. Once cleared, it stays at 0 until software writes a 1 to it at address 0x04.
- R5: In the completion register, bits 15 and 2 are reserved. They always read 0, and writes to them are ignored. The live bits are 14:3 and 1:0.
- R6: eos_req is high exactly while at least one completion flag is set.
- R7: When eos_ack is high and a flag is set, vec_valid is high in that same cycle. vec_addr then holds the vector of the highest set bit position. The vectors, all with upper byte 0xFF and middle byte 0x20, have these low bytes: bit 14 → 0x3C, 13 → 0x3A, 12 → 0x38, 11 → 0x36, 10 → 0x34, 9 → 0x32, 8 → 0x30, 7 → 0x0E, 6 → 0x0C, 5 → 0x0A, 4 → 0x08, 3 → 0x06, 1 → 0x00, 0 → 0x02. With no flag set, vec_valid stays low.
- R8: For a source that is not shared, the acknowledge clears that source's completion flag on the edge where the acknowledge is high.
- R9: Bit 11 is shared by cap_pend[1:0] and bit 12 by cap_pend[3:2]. An acknowledge does not clear these flags. Each one clears on an edge where both of its pending inputs are low.
- R10: If, in one cycle, a software write to the enable or completion register and a count-to-zero event touch the same bit, the hardware result (enable 0, flag 1) wins.
- R11: ctl_mode equals ctl_byte[7:5] and ctl_arg equals ctl_byte[4:0].
- R12: A write to 0x04 or 0x06 loads the live bits of that register from reg_wdata. Address 0x08 returns cap_pend in bits 3:0. Reads are combinational on reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| xfer_stb | input | 16 | Per-bit transfer-completed strobe |
| cap_pend | input | 4 | Capture-channel pending inputs for the shared sources |
| eos_req | output | 1 | End-of-service interrupt request |
| eos_ack | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector output valid |
| vec_addr | output | 24 | Vector address of the winning source |
| ctl_byte | input | 8 | Channel control byte |
| ctl_mode | output | 3 | Decoded mode field |
| ctl_arg | output | 5 | Mode-dependent argument field |

## Verification
The three kinds of result arrive at different times. Register state, counters and eos_req change on the rising edge after the stimulus. reg_rdata then follows reg_addr within the same cycle. vec_valid and vec_addr respond to eos_ack in the cycle it is asserted, before any edge, and they are computed from the flags as they stand before that edge. The bench drives every input on the falling edge. It checks the vector a fraction of a nanosecond after raising the acknowledge. It reads back enable, completion and counter state early in the next low phase, after the edge has updated its model, so each result is compared in the cycle it is due.

// File: rtl/xdi_pkg.sv
// Package: shared constants for the transfer-completion interrupt controller.
// Assumes a 16-bit register view with two reserved positions and two shared sources.
package xdi_pkg;
    localparam int NBITS    = 16;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int CNT_W    = 8;
    localparam int VEC_W    = 24;
    localparam int IDX_W    = $clog2(NBITS);

    localparam logic [ADDR_W-1:0] A_SEL      = 6'h04;
    localparam logic [ADDR_W-1:0] A_DONE     = 6'h06;
    localparam logic [ADDR_W-1:0] A_PEND     = 6'h08;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 6'h20;

    localparam logic [NBITS-1:0] LIVE_MASK   = 16'h7FFB;
    localparam logic [NBITS-1:0] SHARED_MASK = 16'h1800;
    localparam int               SHARED_LO   = 11;

    // Vector address for a completion-register bit position.
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] b);
        logic [7:0] lo;
        if (b >= 4'd8)       lo = 8'h30 + 8'(2 * (b - 4'd8));
        else if (b >= 4'd3)  lo = 8'h06 + 8'(2 * (b - 4'd3));
        else if (b == 4'd1)  lo = 8'h00;
        else                 lo = 8'h02;
        return {16'hFF20, lo};
    endfunction
endpackage

// File: rtl/xdi_chan.sv
// Per-source channel state: enable bit, transfer counter and completion flag.
// Assumes at most one transfer strobe per cycle; a hardware count-to-zero event
// overrides any software write to the same enable or completion bit.
module xdi_chan #(
    parameter int CNT_W  = 8,
    parameter bit SHARED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic             sel_wd,
    input  logic             done_we,
    input  logic             done_wd,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wd,
    input  logic             xfer_stb,
    input  logic             ack_win,
    input  logic             pend_clear,
    output logic             sel_q,
    output logic             done_q,
    output logic [CNT_W-1:0] cnt_q
);
    logic active;
    logic terminal;
    logic flag_release;

    // Strobe counts only on an enabled channel with transfers left.
    assign active       = sel_q & xfer_stb & (cnt_q != '0);
    assign terminal     = active & (cnt_q == CNT_W'(1));
    assign flag_release = SHARED ? pend_clear : ack_win;

    // Counter: software load, else decrement on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_we)  cnt_q <= cnt_wd;
        else if (active)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // Enable bit: hardware clear on terminal count beats a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= 1'b0;
        else if (terminal) sel_q <= 1'b0;
        else if (sel_we)   sel_q <= sel_wd;
    end

    // Completion flag: hardware set wins, then software write, then release.
    always_ff @(posedge clk) begin
        if (!rst_n)            done_q <= 1'b0;
        else if (terminal)     done_q <= 1'b1;
        else if (done_we)      done_q <= done_wd;
        else if (flag_release) done_q <= 1'b0;
    end

    a_r3_terminal_update: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> (!sel_q && done_q));
    a_r4_no_hw_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> $past(sel_we));
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !(sel_q && xfer_stb)) |=> $stable(cnt_q));
    a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (terminal && sel_we) |=> !sel_q);

    if (SHARED) begin : g_shared
        a_r9_shared_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (done_q && !pend_clear && !done_we) |=> done_q);
    end else begin : g_plain
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_win && !done_we && !terminal) |=> !done_q);
    end
endmodule

// File: rtl/xdi_prio.sv
// Highest-position picker: on acknowledge, selects the top set completion flag,
// returns its vector and a one-hot release mask. Purely combinational.
module xdi_prio
    import xdi_pkg::*;
#(
    parameter int N = NBITS
) (
    input  logic [N-1:0]     done_vec,
    input  logic             ack,
    output logic [N-1:0]     win_oh,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr
);
    localparam int IW = $clog2(N);
    logic [IW-1:0] top_idx;
    logic          found;

    // Scan upward so the highest set bit is the one kept.
    always_comb begin
        top_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (done_vec[i]) begin
                top_idx = IW'(i);
                found   = 1'b1;
            end
        end
    end

    assign vec_valid = ack & found;
    assign vec_addr  = vec_of(IDX_W'(top_idx));
    assign win_oh    = vec_valid ? (N'(1) << top_idx) : '0;
endmodule

// File: rtl/xdi_mode_dec.sv
// Control-byte decode: splits the mode select from the mode-specific argument.
module xdi_mode_dec (
    input  logic [7:0] ctl_byte,
    output logic [2:0] ctl_mode,
    output logic [4:0] ctl_arg
);
    // Field split only; meaning of the argument is left to the transfer engine.
    assign ctl_mode = ctl_byte[7:5];
    assign ctl_arg  = ctl_byte[4:0];
endmodule

// File: rtl/xfer_done_intc.sv
// Top: transfer-completion interrupt controller. Holds one channel per live
// register bit, a register port for software, the priority vector picker and
// the control-byte decode. Assumes synchronous active-low reset.
module xfer_done_intc
    import xdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NBITS-1:0]  xfer_stb,
    input  logic [3:0]        cap_pend,
    output logic              eos_req,
    input  logic              eos_ack,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_addr,
    input  logic [7:0]        ctl_byte,
    output logic [2:0]        ctl_mode,
    output logic [4:0]        ctl_arg
);
    logic [NBITS-1:0] sel_vec;
    logic [NBITS-1:0] done_vec;
    logic [NBITS-1:0] win_oh;
    logic [CNT_W-1:0] cnt_arr [NBITS];
    logic             sel_we;
    logic             done_we;

    assign sel_we  = reg_we && (reg_addr == A_SEL);
    assign done_we = reg_we && (reg_addr == A_DONE);

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        if (LIVE_MASK[b]) begin : g_live
            logic cnt_we;
            logic pclr;
            assign cnt_we = reg_we && (reg_addr == (A_CNT_BASE + ADDR_W'(b)));
            if (SHARED_MASK[b]) begin : g_pc
                assign pclr = ~|cap_pend[2*(b-SHARED_LO) +: 2];
            end else begin : g_npc
                assign pclr = 1'b0;
            end
            xdi_chan #(.CNT_W(CNT_W), .SHARED(SHARED_MASK[b])) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel_we     (sel_we),
                .sel_wd     (reg_wdata[b]),
                .done_we    (done_we),
                .done_wd    (reg_wdata[b]),
                .cnt_we     (cnt_we),
                .cnt_wd     (reg_wdata[CNT_W-1:0]),
                .xfer_stb   (xfer_stb[b]),
                .ack_win    (win_oh[b]),
                .pend_clear (pclr),
                .sel_q      (sel_vec[b]),
                .done_q     (done_vec[b]),
                .cnt_q      (cnt_arr[b])
            );
        end else begin : g_rsvd
            logic unused_stb;
            assign unused_stb  = xfer_stb[b];
            assign sel_vec[b]  = 1'b0;
            assign done_vec[b] = 1'b0;
            assign cnt_arr[b]  = '0;
        end
    end

    xdi_prio #(.N(NBITS)) u_prio (
        .done_vec  (done_vec),
        .ack       (eos_ack),
        .win_oh    (win_oh),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr)
    );

    xdi_mode_dec u_mode (
        .ctl_byte (ctl_byte),
        .ctl_mode (ctl_mode),
        .ctl_arg  (ctl_arg)
    );

    // Request stays up while any completion flag is set.
    assign eos_req = |done_vec;

    // Combinational read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_SEL)                 reg_rdata = sel_vec;
        else if (reg_addr == A_DONE)           reg_rdata = done_vec;
        else if (reg_addr == A_PEND)           reg_rdata = DATA_W'(cap_pend);
        else if (reg_addr[5:4] == 2'b10)       reg_rdata = DATA_W'(cnt_arr[reg_addr[3:0]]);
    end

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_DONE) |-> ((reg_rdata & ~LIVE_MASK) == '0));
endmodule

// File: tb/xfer_done_intc_tb.sv
`timescale 1ns/10ps
module xfer_done_intc_tb;
    localparam real CLK_NS = 8.0;
    localparam logic [15:0] LIVE = 16'h7FFB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] xfer_stb = '0;
    logic [3:0]  cap_pend = '0;
    logic        eos_req;
    logic        eos_ack = 1'b0;
    logic        vec_valid;
    logic [23:0] vec_addr;
    logic [7:0]  ctl_byte = '0;
    logic [2:0]  ctl_mode;
    logic [4:0]  ctl_arg;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_sel, m_done;
    logic [7:0]  m_cnt [16];

    always #(CLK_NS/2) clk = ~clk;

    xfer_done_intc u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_stb(xfer_stb),
        .cap_pend(cap_pend), .eos_req(eos_req), .eos_ack(eos_ack),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .ctl_byte(ctl_byte),
        .ctl_mode(ctl_mode), .ctl_arg(ctl_arg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_vec(input int b);
        case (b)
            14: return 24'hFF203C;  13: return 24'hFF203A;  12: return 24'hFF2038;
            11: return 24'hFF2036;  10: return 24'hFF2034;  9:  return 24'hFF2032;
            8:  return 24'hFF2030;  7:  return 24'hFF200E;  6:  return 24'hFF200C;
            5:  return 24'hFF200A;  4:  return 24'hFF2008;  3:  return 24'hFF2006;
            1:  return 24'hFF2000;  0:  return 24'hFF2002;
            default: return 24'h0;
        endcase
    endfunction

    function automatic int top_bit(input logic [15:0] v);
        int t = -1;
        for (int i = 0; i < 16; i++) if (v[i]) t = i;
        return t;
    endfunction

    task automatic model_reset();
        m_sel = '0; m_done = '0;
        for (int i = 0; i < 16; i++) m_cnt[i] = '0;
    endtask

    // Model one rising edge from the pre-edge state and the driven inputs.
    task automatic model_step(input logic we, input logic [5:0] a, input logic [15:0] wd,
                              input logic [15:0] stb, input logic ack, input logic [3:0] pend);
        logic [15:0] n_sel, n_done;
        logic [7:0]  n_cnt [16];
        int w;
        logic term;
        w = top_bit(m_done);
        n_sel = m_sel; n_done = m_done;
        for (int b = 0; b < 16; b++) begin
            n_cnt[b] = m_cnt[b];
            if (LIVE[b]) begin
                term = stb[b] && m_sel[b] && (m_cnt[b] == 8'd1);
                if (we && a == 6'(32 + b)) n_cnt[b] = wd[7:0];
                else if (stb[b] && m_sel[b] && m_cnt[b] != 0) n_cnt[b] = m_cnt[b] - 8'd1;
                if (term) n_sel[b] = 1'b0;
                else if (we && a == 6'h04) n_sel[b] = wd[b];
                if (term) n_done[b] = 1'b1;
                else if (we && a == 6'h06) n_done[b] = wd[b];
                else if (b == 11) begin if (pend[1:0] == 2'b00) n_done[b] = 1'b0; end
                else if (b == 12) begin if (pend[3:2] == 2'b00) n_done[b] = 1'b0; end
                else if (ack && w == b) n_done[b] = 1'b0;
            end
        end
        m_sel = n_sel; m_done = n_done;
        for (int b = 0; b < 16; b++) m_cnt[b] = n_cnt[b];
    endtask

    // Called in the low phase: compare readable state with the model.
    task automatic check_state(input int ci);
        reg_we = 1'b0;
        reg_addr = 6'h04; #0.2;
        chk("R4/R12 enable register", reg_rdata, m_sel);
        reg_addr = 6'h06; #0.2;
        chk("R3/R8/R9 completion register", reg_rdata, m_done);
        reg_addr = 6'(32 + ci); #0.2;
        chk("R2 counter", reg_rdata, {8'h0, m_cnt[ci]});
        chk("R6 request", eos_req, (m_done != 0));
    endtask

    // One cycle: drive at falling edge, check vector, step model at rising edge.
    task automatic cycle(input logic we, input logic [5:0] a, input logic [15:0] wd,
                         input logic [15:0] stb, input logic ack, input logic [3:0] pend);
        reg_we = we; reg_addr = a; reg_wdata = wd; xfer_stb = stb;
        eos_ack = ack; cap_pend = pend;
        #0.5;
        if (ack) begin
            chk("R7 vector valid", vec_valid, (m_done != 0));
            if (m_done != 0) chk("R7 vector address", vec_addr, exp_vec(top_bit(m_done)));
        end
        @(posedge clk);
        model_step(we, a, wd, stb, ack, pend);
        @(negedge clk);
        reg_we = 1'b0; xfer_stb = '0; eos_ack = 1'b0;
    endtask

    task automatic idle();
        cycle(1'b0, 6'h00, 16'h0, 16'h0, 1'b0, cap_pend);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        reg_we = 1'b0; reg_addr = a; #0.2; d = reg_rdata;
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] d;
        model_reset();
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(6'h06, d); chk("R1 completion after reset", d, 16'h0000);
        rd(6'h04, d); chk("R1 enable after reset", d, 16'h0000);
        rd(6'h23, d); chk("R1 counter after reset", d, 16'h0000);
        chk("R1 request after reset", eos_req, 1'b0);

        // R11 control-byte decode
        ctl_byte = 8'hB7; #0.2;
        chk("R11 mode", ctl_mode, 3'd5); chk("R11 arg", ctl_arg, 5'h17);
        ctl_byte = 8'h4A; #0.2;
        chk("R11 mode", ctl_mode, 3'd2); chk("R11 arg", ctl_arg, 5'h0A);

        // R2 load, ignored strobe while disabled, decrement; R3 terminal
        cycle(1'b1, 6'h24, 16'h0003, 16'h0, 1'b0, 4'h0);
        cycle(1'b0, 6'h00, 16'h0, 16'h0010, 1'b0, 4'h0);
        rd(6'h24, d); chk("R2 strobe ignored while disabled", d, 16'h0003);
        cycle(1'b1, 6'h04, 16'h0010, 16'h0, 1'b0, 4'h0);
        cycle(1'b0, 6'h00, 16'h0, 16'h0010, 1'b0, 4'h0);
        rd(6'h24, d); chk("R2 decrement", d, 16'h0002);
        cycle(1'b0, 6'h00, 16'h0, 16'h0010, 1'b0, 4'h0);
        cycle(1'b0, 6'h00, 16'h0, 16'h0010, 1'b0, 4'h0);
        rd(6'h04, d); chk("R3 enable cleared at zero", d, 16'h0000);
        rd(6'h06, d); chk("R3 flag set at zero", d, 16'h0010);
        chk("R6 request up", eos_req, 1'b1);
        cycle(1'b0, 6'h00, 16'h0, 16'h0010, 1'b0, 4'h0);
        idle();
        rd(6'h04, d); chk("R4 enable stays clear", d, 16'h0000);

        // R12 software write, R7 priority, R8 ack release
        cycle(1'b1, 6'h06, 16'h0410, 16'h0, 1'b0, 4'h0);
        rd(6'h06, d); chk("R12 completion write", d, 16'h0410);
        eos_ack = 1'b1; #0.2;
        chk("R7 highest wins", vec_addr, 24'hFF2034);
        cycle(1'b0, 6'h00, 16'h0, 16'h0, 1'b1, 4'h0);
        rd(6'h06, d); chk("R8 ack clears winner", d, 16'h0010);
        eos_ack = 1'b1; #0.2;
        chk("R7 next vector", vec_addr, 24'hFF2008);
        cycle(1'b0, 6'h00, 16'h0, 16'h0, 1'b1, 4'h0);
        chk("R6 request drops", eos_req, 1'b0);
        eos_ack = 1'b1; #0.2;
        chk("R7 no flag no valid", vec_valid, 1'b0);
        eos_ack = 1'b0;

        // R5 reserved bits
        cycle(1'b1, 6'h06, 16'hFFFF, 16'h0, 1'b0, 4'h1);
        rd(6'h06, d); chk("R5 reserved bits read zero", d, 16'h7FFB);
        cycle(1'b1, 6'h06, 16'h0800, 16'h0, 1'b0, 4'h1);

        // R9 shared source: ack does not clear, pending low does
        rd(6'h08, d); chk("R12 pending view", d, 16'h0001);
        eos_ack = 1'b1; #0.2;
        chk("R7 shared vector", vec_addr, 24'hFF2036);
        cycle(1'b0, 6'h00, 16'h0, 16'h0, 1'b1, 4'h1);
        rd(6'h06, d); chk("R9 ack leaves shared flag", d, 16'h0800);
        cycle(1'b0, 6'h00, 16'h0, 16'h0, 1'b0, 4'h0);
        rd(6'h06, d); chk("R9 pending clear releases", d, 16'h0000);

        // R10 collisions
        cycle(1'b1, 6'h28, 16'h0001, 16'h0, 1'b0, 4'h0);
        cycle(1'b1, 6'h29, 16'h0001, 16'h0, 1'b0, 4'h0);
        cycle(1'b1, 6'h04, 16'h0300, 16'h0, 1'b0, 4'h0);
        cycle(1'b1, 6'h04, 16'h0300, 16'h0100, 1'b0, 4'h0);
        rd(6'h04, d); chk("R10 enable write loses", d, 16'h0200);
        rd(6'h06, d); chk("R10 flag set", d, 16'h0100);
        cycle(1'b1, 6'h06, 16'h0000, 16'h0200, 1'b0, 4'h0);
        rd(6'h06, d); chk("R10 completion write loses", d, 16'h0200);
        cycle(1'b1, 6'h06, 16'h0000, 16'h0, 1'b0, 4'h0);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [15:0] wd, stb;
            logic [5:0]  a;
            logic        we, ack;
            logic [3:0]  pend;
            check_state(n % 16);
            op = $urandom % 10;
            we = 1'b1; a = 6'h00; wd = 16'($urandom);
            if (op < 2)       a = 6'h04;
            else if (op == 2) a = 6'h06;
            else if (op < 5) begin a = 6'(32 + ($urandom % 16)); wd = 16'(1 + $urandom % 3); end
            else we = 1'b0;
            stb  = 16'($urandom) & 16'($urandom);
            ack  = ($urandom % 4) == 0;
            pend = (($urandom % 5) == 0) ? 4'($urandom) : cap_pend;
            cycle(we, a, wd, stb, ack, pend);
        end
        check_state(0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule